// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

The block merges a set of reset requests into one system reset and runs a timed sequence on a bidirectional reset pad. The requests come from power-on, low-voltage detection, a watchdog timeout, an illegal-opcode detector, a debug unit, the external pad and a clock-loss monitor. When any request arrives, the system reset is asserted. The pad is then driven low for a fixed number of bus cycles and released. After a second fixed interval the pad level is sampled. If the pad is still low at that point, something outside the block is holding it low, and the external pin is recorded as a cause.

A cause register keeps the reasons for the most recent reset. It is cleared and reloaded when a new sequence starts. Requests that arrive while a sequence is running are added to it and restart the drive-low phase. Power-on is the asynchronous reset of the block and leaves only its own cause bit set. Counting advances only on cycles where the bus-clock enable is high, and that enable pulses once every two reference clocks. The system reset is released only when the sampling step has finished and no request is active.

Top module: `reset_sequencer`

## Requirements
- R1: While `porReq` is high, and at any point in a sequence when it rises, `sysRst` and `padDriveLow` are 1 and `causeStatus` is 6'b000001 (bit 0 = power-on). A full sequence follows once `porReq` falls.
- R2: A sequence holds `padDriveLow` at 1 for exactly DRIVE_CYCLES clock edges that have `busEn` high, counted from the start or from the most recent restart.
- R3: After the drive phase, `padDriveLow` is 0 and `sysRst` stays 1 for exactly SAMPLE_DELAY further edges that have `busEn` high. `sysRst` then falls, provided no request is active.
- R4: Cause bit 4 (external pin) is set only if `padIn` is 0 at the final sampling edge. Otherwise it stays 0.
- R5: A request that arrives while the block is idle starts a sequence. It clears `causeStatus` and then loads the bit of each active request: bit 1 low-voltage, bit 2 watchdog, bit 3 illegal opcode, bit 5 clock loss.
- R6: A debug request runs a full sequence but sets no cause bit.
- R7: Any request other than power-on, arriving during a sequence, keeps `sysRst` at 1. It restarts the drive phase from a count of zero and ORs its bit into `causeStatus`.
- R8: On edges with `busEn` low, neither phase advances, and `padDriveLow` and `sysRst` hold their values.
- R9: A low `padIn` while the block is idle starts a sequence, even if the pad returns high on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| porReq | input | 1 | Power-on request, asynchronous, active high |
| busEn | input | 1 | Bus-clock enable, one pulse every two reference clocks |
| lvdReq | input | 1 | Low-voltage request |
| wdtReq | input | 1 | Watchdog timeout request |
| illegalReq | input | 1 | Illegal-opcode request |
| debugReq | input | 1 | Debug-forced request |
| clkLossReq | input | 1 | Clock loss-of-lock or loss-of-clock request |
| padIn | input | 1 | Sensed level of the reset pad |
| padDriveLow | output | 1 | 1 drives the reset pad low |
| sysRst | output | 1 | Internal system reset, active high |
| causeStatus | output | 6 | Causes of the most recent reset |

## Verification
The bench builds the block with its default counts of 34 drive cycles and 38 sampling-delay cycles. These are short enough for every phase to be measured pulse by pulse in each scenario. `busEn` runs at half rate and can be paused, so stalls can be placed in the middle of the drive phase and shown not to move the counts. The pad is modelled as the block's own pull-down combined with an external hold. This lets the bench hold the pad low through the sampling edge, or release it before that edge, and check which of the two sets the pin cause.

// File: rtl/reset_seq_pkg.sv
package reset_seq_pkg;
  localparam int CAUSE_W = 6;
  localparam int POR_BIT = 0;
  localparam int LVD_BIT = 1;
  localparam int WDT_BIT = 2;
  localparam int ILL_BIT = 3;
  localparam int PIN_BIT = 4;
  localparam int CLK_BIT = 5;

  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_DRIVE   = 2'd1,
    SEQ_RELEASE = 2'd2
  } seqState_t;

  typedef struct packed {
    logic startSeq;
    logic mergeReq;
    logic samplePin;
  } seqStrobe_t;
endpackage

// File: rtl/reset_seq_ctrl.sv
module reset_seq_ctrl
  import reset_seq_pkg::*;
#(
  parameter int DRIVE_CYCLES = 34,
  parameter int SAMPLE_DELAY = 38
) (
  input  logic       clk,
  input  logic       porReq,
  input  logic       busEn,
  input  logic       anyIntReq,
  input  logic       padIn,
  output seqStrobe_t strobe,
  output logic       padDriveLow,
  output logic       sysRst
);
  localparam int CNT_MAX = (DRIVE_CYCLES > SAMPLE_DELAY) ? DRIVE_CYCLES : SAMPLE_DELAY;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] DRIVE_LAST  = CNT_W'(DRIVE_CYCLES - 1);
  localparam logic [CNT_W-1:0] SAMPLE_LAST = CNT_W'(SAMPLE_DELAY - 1);

  seqState_t        state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    strobe    = '0;
    unique case (state)
      SEQ_IDLE: begin
        if (anyIntReq || !padIn) begin
          stateNext       = SEQ_DRIVE;
          cntNext         = '0;
          strobe.startSeq = 1'b1;
        end
      end
      SEQ_DRIVE, SEQ_RELEASE: begin
        if (anyIntReq) begin
          stateNext       = SEQ_DRIVE;
          cntNext         = '0;
          strobe.mergeReq = 1'b1;
        end else if (busEn) begin
          if (state == SEQ_DRIVE && cnt == DRIVE_LAST) begin
            stateNext = SEQ_RELEASE;
            cntNext   = '0;
          end else if (state == SEQ_RELEASE && cnt == SAMPLE_LAST) begin
            stateNext        = SEQ_IDLE;
            cntNext          = '0;
            strobe.samplePin = 1'b1;
          end else begin
            cntNext = cnt + 1'b1;
          end
        end
      end
      default: begin
        stateNext = SEQ_DRIVE;
        cntNext   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or posedge porReq) begin
    if (porReq) begin
      state <= SEQ_DRIVE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

  assign padDriveLow = (state == SEQ_DRIVE);
  assign sysRst      = (state != SEQ_IDLE);

  // R7: a request inside a sequence restarts the drive phase from zero
  assert_restart_drive_R7: assert property (@(posedge clk) disable iff (porReq)
    (state != SEQ_IDLE && anyIntReq) |=> (state == SEQ_DRIVE && cnt == '0));

  // R8: with no bus enable the sequence holds still
  assert_hold_no_enable_R8: assert property (@(posedge clk) disable iff (porReq)
    (state != SEQ_IDLE && !anyIntReq && !busEn) |=> ($stable(cnt) && $stable(state)));

  // R2: the pad is released only after the last drive cycle
  assert_drive_length_R2: assert property (@(posedge clk) disable iff (porReq)
    ($fell(padDriveLow) && sysRst) |-> ($past(cnt) == DRIVE_LAST && $past(busEn)));

  // R3: reset ends only from the final release cycle
  assert_release_length_R3: assert property (@(posedge clk) disable iff (porReq)
    $fell(sysRst) |-> ($past(state) == SEQ_RELEASE && $past(cnt) == SAMPLE_LAST && $past(busEn)));
endmodule

// File: rtl/reset_seq_status.sv
module reset_seq_status
  import reset_seq_pkg::*;
(
  input  logic               clk,
  input  logic               porReq,
  input  logic               lvdReq,
  input  logic               wdtReq,
  input  logic               illegalReq,
  input  logic               clkLossReq,
  input  logic               padIn,
  input  seqStrobe_t         strobe,
  output logic [CAUSE_W-1:0] causeStatus
);
  localparam logic [CAUSE_W-1:0] POR_ONLY = CAUSE_W'(1) << POR_BIT;
  localparam logic [CAUSE_W-1:0] PIN_MASK = CAUSE_W'(1) << PIN_BIT;

  logic [CAUSE_W-1:0] reqBits;

  always_comb begin
    reqBits          = '0;
    reqBits[LVD_BIT] = lvdReq;
    reqBits[WDT_BIT] = wdtReq;
    reqBits[ILL_BIT] = illegalReq;
    reqBits[CLK_BIT] = clkLossReq;
  end

  always_ff @(posedge clk or posedge porReq) begin
    if (porReq) begin
      causeStatus <= POR_ONLY;
    end else begin
      if (strobe.startSeq)      causeStatus <= reqBits;
      else if (strobe.mergeReq) causeStatus <= causeStatus | reqBits;
      if (strobe.samplePin)     causeStatus[PIN_BIT] <= !padIn;
    end
  end

  // R4: the pin cause appears only from a low pad at the sampling edge
  assert_pin_from_sample_R4: assert property (@(posedge clk) disable iff (porReq)
    $rose(causeStatus[PIN_BIT]) |-> ($past(strobe.samplePin) && !$past(padIn)));

  // R5: a new sequence drops the power-on and pin causes
  assert_new_seq_clears_R5: assert property (@(posedge clk) disable iff (porReq)
    strobe.startSeq |=> (!causeStatus[POR_BIT] && !causeStatus[PIN_BIT]));

  // R6: request causes change only on a start or a merge
  assert_cause_source_R6: assert property (@(posedge clk) disable iff (porReq)
    ((causeStatus & ~PIN_MASK) != $past(causeStatus & ~PIN_MASK))
      |-> ($past(strobe.startSeq) || $past(strobe.mergeReq)));
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import reset_seq_pkg::*;
#(
  parameter int DRIVE_CYCLES = 34,
  parameter int SAMPLE_DELAY = 38
) (
  input  logic               clk,
  input  logic               porReq,
  input  logic               busEn,
  input  logic               lvdReq,
  input  logic               wdtReq,
  input  logic               illegalReq,
  input  logic               debugReq,
  input  logic               clkLossReq,
  input  logic               padIn,
  output logic               padDriveLow,
  output logic               sysRst,
  output logic [CAUSE_W-1:0] causeStatus
);
  seqStrobe_t strobe;
  logic       anyIntReq;

  assign anyIntReq = lvdReq | wdtReq | illegalReq | debugReq | clkLossReq;

  reset_seq_ctrl #(
    .DRIVE_CYCLES(DRIVE_CYCLES),
    .SAMPLE_DELAY(SAMPLE_DELAY)
  ) u_ctrl (
    .clk        (clk),
    .porReq     (porReq),
    .busEn      (busEn),
    .anyIntReq  (anyIntReq),
    .padIn      (padIn),
    .strobe     (strobe),
    .padDriveLow(padDriveLow),
    .sysRst     (sysRst)
  );

  reset_seq_status u_status (
    .clk        (clk),
    .porReq     (porReq),
    .lvdReq     (lvdReq),
    .wdtReq     (wdtReq),
    .illegalReq (illegalReq),
    .clkLossReq (clkLossReq),
    .padIn      (padIn),
    .strobe     (strobe),
    .causeStatus(causeStatus)
  );
endmodule

// File: tb/reset_sequencer_bench.sv
module reset_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DRIVE_N = 34;
  localparam int DELAY_N = 38;

  logic clk = 0;
  logic porReq = 1;
  logic busEn = 0;
  logic busOn = 1;
  logic [4:0] reqDrv = '0; // 0 lvd, 1 wdt, 2 illegal, 3 debug, 4 clock loss
  logic extHold = 0;
  logic padIn;
  logic padDriveLow, sysRst;
  logic [5:0] causeStatus;
  int total = 0;
  int failed = 0;

  assign padIn = ~(padDriveLow | extHold);

  reset_sequencer #(.DRIVE_CYCLES(DRIVE_N), .SAMPLE_DELAY(DELAY_N)) u_reset_sequencer (
    .clk(clk), .porReq(porReq), .busEn(busEn),
    .lvdReq(reqDrv[0]), .wdtReq(reqDrv[1]), .illegalReq(reqDrv[2]),
    .debugReq(reqDrv[3]), .clkLossReq(reqDrv[4]), .padIn(padIn),
    .padDriveLow(padDriveLow), .sysRst(sysRst), .causeStatus(causeStatus)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      #1 busEn = busOn ? ~busEn : 1'b0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulseReq(input logic [4:0] bits);
    reqDrv = bits;
    @(negedge clk);
    reqDrv = '0;
  endtask

  task automatic waitPulses(input bit inDrive, input int n);
    int k = 0;
    while (k < n) begin
      @(negedge clk);
      if (busEn && (padDriveLow == inDrive) && sysRst) k++;
    end
  endtask

  // counts drive and release pulses from the current negedge until reset ends
  task automatic runSeq(output int dN, output int rN, input int stallAt);
    int guard = 0;
    dN = 0;
    rN = 0;
    while (guard < 20000) begin
      if (!sysRst) break;
      if (busEn && padDriveLow) begin
        dN++;
        if (dN == stallAt) begin
          busOn = 0;
          for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            check("R8 drive held during stall", padDriveLow, 1);
          end
          busOn = 1;
        end
      end else if (busEn) begin
        rN++;
      end
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic checkSeq(input string tag, input int stallAt);
    int dN, rN;
    runSeq(dN, rN, stallAt);
    check({tag, " R2 drive cycles"}, dN, DRIVE_N);
    check({tag, " R3 release cycles"}, rN, DELAY_N);
    check({tag, " R3 reset released"}, {sysRst, padDriveLow}, 0);
  endtask

  task automatic testPowerOn();
    repeat (4) @(negedge clk);
    check("R1 sysRst during power-on", sysRst, 1);
    check("R1 pad driven during power-on", padDriveLow, 1);
    check("R1 status power-on only", causeStatus, 6'h01);
    porReq = 0;
    checkSeq("por", 0);
    check("R4 no pin cause after power-on", causeStatus, 6'h01);
  endtask

  task automatic testWatchdog();
    @(negedge clk);
    pulseReq(5'b00010);
    check("R5 watchdog starts sequence", sysRst, 1);
    checkSeq("wdt", 0);
    check("R5 watchdog cause bit 2", causeStatus, 6'h04);
  endtask

  task automatic testMulti();
    @(negedge clk);
    pulseReq(5'b10001);
    checkSeq("multi", 0);
    check("R5 low-voltage and clock-loss bits", causeStatus, 6'h22);
  endtask

  task automatic testDebug();
    @(negedge clk);
    pulseReq(5'b01000);
    check("R6 debug starts sequence", sysRst, 1);
    checkSeq("debug", 0);
    check("R6 debug sets no bit", causeStatus, 6'h00);
  endtask

  task automatic testPinHeld();
    int dN, rN;
    @(negedge clk);
    extHold = 1;
    @(negedge clk);
    check("R9 held pin starts sequence", sysRst, 1);
    runSeq(dN, rN, 0);
    extHold = 0;
    check("R2 pin drive cycles", dN, DRIVE_N);
    check("R3 pin release cycles", rN, DELAY_N);
    check("R4 pin cause when low at sample", causeStatus, 6'h10);
    repeat (4) @(negedge clk);
    check("R4 idle after pin released", sysRst, 0);
  endtask

  task automatic testPinShort();
    @(negedge clk);
    extHold = 1;
    @(negedge clk);
    extHold = 0;
    check("R9 short pin pulse starts sequence", sysRst, 1);
    checkSeq("pinshort", 0);
    check("R4 no pin cause when high at sample", causeStatus, 6'h00);
  endtask

  task automatic testRestartDrive();
    @(negedge clk);
    pulseReq(5'b00010);
    waitPulses(1, 20);
    pulseReq(5'b00100);
    checkSeq("restart-drive R7", 0);
    check("R7 merged watchdog and illegal", causeStatus, 6'h0C);
  endtask

  task automatic testRestartRelease();
    @(negedge clk);
    pulseReq(5'b00001);
    waitPulses(0, 10);
    pulseReq(5'b10000);
    check("R7 pad driven again", padDriveLow, 1);
    checkSeq("restart-release R7", 0);
    check("R7 merged low-voltage and clock-loss", causeStatus, 6'h22);
  endtask

  task automatic testStall();
    @(negedge clk);
    pulseReq(5'b00010);
    checkSeq("stall R8", 10);
    check("R8 status after stalled sequence", causeStatus, 6'h04);
  endtask

  task automatic testPorMid();
    @(negedge clk);
    pulseReq(5'b00100);
    waitPulses(1, 10);
    porReq = 1;
    @(negedge clk);
    check("R1 power-on mid sequence status", causeStatus, 6'h01);
    porReq = 0;
    checkSeq("por-mid R1", 0);
    check("R1 status after power-on restart", causeStatus, 6'h01);
  endtask

  initial begin
    @(negedge clk);
    testPowerOn();
    testWatchdog();
    testMulti();
    testDebug();
    testPinHeld();
    testPinShort();
    testRestartDrive();
    testRestartRelease();
    testStall();
    testPorMid();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    failed++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule